// File: doc/BRIEF.md
# Load/store address unit with local-RAM alignment

This block turns one load or store instruction into memory transfers. It forms an effective address in one of three ways. The first uses a register directly. The second adds a register to one of two base registers. The third adds a scaled 5-bit immediate to one of the two base registers. The block then decides where the access goes. Word, long and 64-bit phrase accesses whose effective address falls in a fixed local-RAM window go to a long-wide local RAM port, with the low address bits forced to natural alignment. Every other access goes to an external bus port with its address unchanged.

A phrase access is carried out as two long transfers. The upper half comes from, or goes to, a high-data holding register. A word store into local RAM becomes a read of the containing long followed by a write of the merged long. A load writes its destination only on the cycle that completes the whole instruction. A phrase load updates the holding register at that same point.

Top module: `lram_lsu`

## Requirements
- R1: An effective address in 0xF03000..0xF03FFF inclusive, with size word (code 1), long (code 2) or phrase (code 3), uses only the local port. Any other address, and every byte access (code 0), uses only the external port.
- R2: Addressing modes are selected by mode_i. Code 0 uses rm_i. Code 1 uses base + rm_i. Code 2 uses base + imm_i*4, where an imm_i of 0 counts as 32. Code 3 behaves as code 0. The base is base_a_i when base_sel_i=0 and base_b_i when base_sel_i=1.
- R3: A local long access clears address bits [1:0]. An external long access keeps the effective address and carries ext_size_o=2.
- R4: A local phrase access clears bits [2:0] and makes two long transfers. The first is at the aligned address and carries the holding register (store) or loads it (load). The second is at aligned+4 and carries rn_i (store) or loads the destination (load).
- R5: An external phrase access makes two transfers with ext_size_o=2, at the unmasked effective address and then at that address +4, with the same data order as R4.
- R6: A local word store reads the long at the effective address with bits [1:0] cleared, then writes that long back with rn_i[15:0] merged in. When address bit 1 is set the merge replaces bits [15:0]; when it is clear it replaces bits [31:16].
- R7: A local word load reads at the effective address with bit 0 cleared. It returns bits [15:0] of the read long, zero-extended.
- R8: External word and byte accesses carry ext_size_o=1 and 0 respectively at the unchanged address. Loads return the low 16 or 8 bits of ext_rdata_i, zero-extended.
- R9: While a port's valid is high and its ready is low, valid, address, write enable and write data stay unchanged. Each cycle with valid and ready high completes exactly one transfer.
- R10: done_o pulses for one cycle, in the cycle after the last transfer. rd_we_o is high only on that cycle and only for loads. During that cycle hi_data_o still shows its old value.
- R11: start_i is ignored while an instruction is in progress. No transfer follows done_o until the next accepted start.
- R12: hi_wr_i loads hi_wdata_i into the holding register on the next edge. If a phrase load completes on the same edge, the phrase load takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken when idle) |
| store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 phrase |
| mode_i | input | 2 | Addressing mode code |
| base_sel_i | input | 1 | Selects base_a_i (0) or base_b_i (1) |
| rm_i | input | 32 | Address or index register value |
| base_a_i | input | 32 | First base register value |
| base_b_i | input | 32 | Second base register value |
| imm_i | input | 5 | Immediate offset field |
| rn_i | input | 32 | Store data |
| hi_wr_i | input | 1 | Write the holding register |
| hi_wdata_i | input | 32 | Holding register write value |
| lram_valid_o | output | 1 | Local port request |
| lram_ready_i | input | 1 | Local port accepts request |
| lram_we_o | output | 1 | Local port write |
| lram_addr_o | output | 32 | Local port byte address |
| lram_wdata_o | output | 32 | Local port write data |
| lram_rdata_i | input | 32 | Local port read data, valid with ready |
| ext_valid_o | output | 1 | External port request |
| ext_ready_i | input | 1 | External port accepts request |
| ext_we_o | output | 1 | External port write |
| ext_size_o | output | 2 | External transfer size code |
| ext_addr_o | output | 32 | External byte address |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data, valid with ready |
| done_o | output | 1 | Instruction complete |
| rd_we_o | output | 1 | Destination register write |
| rd_data_o | output | 32 | Destination register value |
| hi_data_o | output | 32 | Holding register content |

## Verification
The assertions assume that each port returns read data in the cycle in which it raises ready, and that a start pulse counts only when the block is idle. The bench's responders meet this. At every falling edge they draw ready at random and place on the read data a value computed from the address presented. Some instructions deliberately hold start_i high into the busy period with a different register value. Addresses are drawn around both edges of the local window, so that in-window and out-of-window cases both occur often.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_PHRASE} size_e;
  typedef enum logic [1:0] {AM_IND, AM_BASE_REG, AM_BASE_IMM, AM_RSVD} amode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1, ST_FIN} st_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int IMM_W = 5,
  parameter logic [AW-1:0] WIN_LO = 32'h00F0_3000,
  parameter logic [AW-1:0] WIN_HI = 32'h00F0_3FFF
) (
  input  logic [1:0]    mode_i,
  input  logic          base_sel_i,
  input  logic [AW-1:0] rm_i,
  input  logic [AW-1:0] base_a_i,
  input  logic [AW-1:0] base_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]    size_i,
  input  logic          store_i,
  output logic [AW-1:0] addr0_o,
  output logic [AW-1:0] addr1_o,
  output logic          local_o,
  output logic          bit1_o
);
  localparam logic [IMM_W:0] IMM_ZERO_VAL = (IMM_W+1)'(1) << IMM_W;

  size_e         sz;
  amode_e        md;
  logic [AW-1:0] base, ea, imm_off;
  logic [IMM_W:0] imm_ext;
  logic [2:0]    clr;
  logic          in_win;

  always_comb begin
    sz      = size_e'(size_i);
    md      = amode_e'(mode_i);
    base    = base_sel_i ? base_b_i : base_a_i;
    imm_ext = (imm_i == '0) ? IMM_ZERO_VAL : {1'b0, imm_i};
    imm_off = AW'(imm_ext) << 2;
    unique case (md)
      AM_BASE_REG: ea = base + rm_i;
      AM_BASE_IMM: ea = base + imm_off;
      default:     ea = rm_i;
    endcase
    in_win  = (ea >= WIN_LO) && (ea <= WIN_HI);
    local_o = in_win && (sz != SZ_BYTE);
    clr     = 3'b000;
    if (local_o) begin
      unique case (sz)
        SZ_WORD:   clr = store_i ? 3'b011 : 3'b001;
        SZ_LONG:   clr = 3'b011;
        SZ_PHRASE: clr = 3'b111;
        default:   clr = 3'b000;
      endcase
    end
    addr0_o = ea & ~{{(AW-3){1'b0}}, clr};
    addr1_o = (sz == SZ_PHRASE) ? addr0_o + AW'(4) : addr0_o;
    bit1_o  = ea[1];
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_i,
  input  logic fire_i,
  output logic accept_o,
  output logic active_o,
  output logic beat_o,
  output logic fin_o
);
  st_e state_q, state_d;

  always_comb begin
    accept_o = start_i && (state_q == ST_IDLE);
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_BEAT0;
      ST_BEAT0: if (fire_i) state_d = two_i ? ST_BEAT1 : ST_FIN;
      ST_BEAT1: if (fire_i) state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign active_o = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign beat_o   = (state_q == ST_BEAT1);
  assign fin_o    = (state_q == ST_FIN);

  // R10: completion only ever follows a completed transfer
  a_r10_fin_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> $past(fire_i));
  // R11: a new start is never taken while a transfer is pending
  a_r11_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !accept_o);
endmodule

// File: rtl/lsu_data.sv
module lsu_data
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          beat_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] rn_i,
  input  logic [DW-1:0] d0_i,
  input  logic [DW-1:0] d1_i,
  input  logic          hsel_i,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rd_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] merged;
  size_e         sz;

  // bit1 set -> new half goes to the low half, else to the high half
  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign merged[h*HW +: HW] = hsel_i ? rn_i[HW-1:0] : d0_i[h*HW +: HW];
    end else begin : g_hi
      assign merged[h*HW +: HW] = hsel_i ? d0_i[h*HW +: HW] : rn_i[HW-1:0];
    end
  end

  always_comb begin
    sz = size_e'(size_i);
    if (!beat_i) wdata_o = (sz == SZ_PHRASE) ? hi_i : rn_i;
    else         wdata_o = (sz == SZ_PHRASE) ? rn_i : merged;
    unique case (sz)
      SZ_BYTE:   rd_o = DW'(d0_i[7:0]);
      SZ_WORD:   rd_o = DW'(d0_i[HW-1:0]);
      SZ_LONG:   rd_o = d0_i;
      default:   rd_o = d1_i;
    endcase
  end
endmodule

// File: rtl/lram_lsu.sv
module lram_lsu
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IMM_W = 5,
  parameter logic [AW-1:0] WIN_LO = 32'h00F0_3000,
  parameter logic [AW-1:0] WIN_HI = 32'h00F0_3FFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             store_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       mode_i,
  input  logic             base_sel_i,
  input  logic [AW-1:0]    rm_i,
  input  logic [AW-1:0]    base_a_i,
  input  logic [AW-1:0]    base_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    rn_i,
  input  logic             hi_wr_i,
  input  logic [DW-1:0]    hi_wdata_i,
  output logic             lram_valid_o,
  input  logic             lram_ready_i,
  output logic             lram_we_o,
  output logic [AW-1:0]    lram_addr_o,
  output logic [DW-1:0]    lram_wdata_o,
  input  logic [DW-1:0]    lram_rdata_i,
  output logic             ext_valid_o,
  input  logic             ext_ready_i,
  output logic             ext_we_o,
  output logic [1:0]       ext_size_o,
  output logic [AW-1:0]    ext_addr_o,
  output logic [DW-1:0]    ext_wdata_o,
  input  logic [DW-1:0]    ext_rdata_i,
  output logic             done_o,
  output logic             rd_we_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    hi_data_o
);
  logic [AW-1:0] ag_a0, ag_a1;
  logic          ag_loc, ag_b1;
  logic          accept, active, beat, fin, fire;

  logic [AW-1:0] a0_q, a1_q;
  logic          loc_q, st_q, two_q, rmw_q, b1_q;
  size_e         sz_q;
  logic [DW-1:0] rn_q, hicap_q, d0_q, d1_q, hi_q, wdata, rdsel;
  logic [AW-1:0] addr;
  logic          we;

  lsu_agen #(.AW(AW), .IMM_W(IMM_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_agen (
    .mode_i(mode_i), .base_sel_i(base_sel_i), .rm_i(rm_i), .base_a_i(base_a_i),
    .base_b_i(base_b_i), .imm_i(imm_i), .size_i(size_i), .store_i(store_i),
    .addr0_o(ag_a0), .addr1_o(ag_a1), .local_o(ag_loc), .bit1_o(ag_b1)
  );

  lsu_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .two_i(two_q), .fire_i(fire),
    .accept_o(accept), .active_o(active), .beat_o(beat), .fin_o(fin)
  );

  lsu_data #(.DW(DW)) u_data (
    .beat_i(beat), .size_i(sz_q), .hi_i(hicap_q), .rn_i(rn_q), .d0_i(d0_q),
    .d1_i(d1_q), .hsel_i(b1_q), .wdata_o(wdata), .rd_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_q <= '0; a1_q <= '0; loc_q <= 1'b0; st_q <= 1'b0; two_q <= 1'b0;
      rmw_q <= 1'b0; b1_q <= 1'b0; sz_q <= SZ_BYTE; rn_q <= '0; hicap_q <= '0;
    end else if (accept) begin
      a0_q    <= ag_a0;
      a1_q    <= ag_a1;
      loc_q   <= ag_loc;
      st_q    <= store_i;
      sz_q    <= size_e'(size_i);
      rmw_q   <= ag_loc && store_i && (size_e'(size_i) == SZ_WORD);
      two_q   <= (size_e'(size_i) == SZ_PHRASE) ||
                 (ag_loc && store_i && (size_e'(size_i) == SZ_WORD));
      b1_q    <= ag_b1;
      rn_q    <= rn_i;
      hicap_q <= hi_q;
    end
  end

  assign rdsel = loc_q ? lram_rdata_i : ext_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d0_q <= '0; d1_q <= '0;
    end else if (fire) begin
      if (beat) d1_q <= rdsel;
      else      d0_q <= rdsel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                hi_q <= '0;
    else if (fin && !st_q && sz_q == SZ_PHRASE) hi_q <= d0_q;
    else if (hi_wr_i)                           hi_q <= hi_wdata_i;
  end

  assign addr = beat ? a1_q : a0_q;
  assign we   = st_q && !(rmw_q && !beat);
  assign fire = (lram_valid_o && lram_ready_i) || (ext_valid_o && ext_ready_i);

  assign lram_valid_o = active && loc_q;
  assign lram_we_o    = we;
  assign lram_addr_o  = addr;
  assign lram_wdata_o = wdata;
  assign ext_valid_o  = active && !loc_q;
  assign ext_we_o     = we;
  assign ext_size_o   = (sz_q == SZ_PHRASE) ? 2'(SZ_LONG) : 2'(sz_q);
  assign ext_addr_o   = addr;
  assign ext_wdata_o  = wdata;
  assign done_o       = fin;
  assign rd_we_o      = fin && !st_q;
  assign hi_data_o    = hi_q;

  // R1: local requests stay inside the window
  a_r1_local_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lram_valid_o |-> (lram_addr_o >= WIN_LO) && (lram_addr_o <= WIN_HI));
  // R3: local addresses are at least half-word aligned
  a_r3_local_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lram_valid_o |-> !lram_addr_o[0]);
  // R9: request held until accepted
  a_r9_lram_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lram_valid_o && !lram_ready_i |=> lram_valid_o && $stable(lram_addr_o) &&
      $stable(lram_wdata_o) && $stable(lram_we_o));
  a_r9_ext_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o && !ext_ready_i |=> ext_valid_o && $stable(ext_addr_o) &&
      $stable(ext_wdata_o) && $stable(ext_we_o) && $stable(ext_size_o));
  // R1: never both ports at once
  a_r1_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lram_valid_o && ext_valid_o));
  // R10: single-cycle completion pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: no request is open while completion is flagged
  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lram_valid_o && !ext_valid_o);
endmodule

// File: tb/lram_lsu_tb.sv
module lram_lsu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WLO = 32'h00F0_3000;
  localparam logic [31:0] WHI = 32'h00F0_3FFF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, store_i = 0, base_sel_i = 0, hi_wr_i = 0;
  logic [1:0] size_i = 0, mode_i = 0;
  logic [31:0] rm_i = 0, base_a_i = 0, base_b_i = 0, rn_i = 0, hi_wdata_i = 0;
  logic [4:0] imm_i = 0;
  logic lram_valid_o, lram_ready_i = 0, lram_we_o;
  logic [31:0] lram_addr_o, lram_wdata_o, lram_rdata_i = 0;
  logic ext_valid_o, ext_ready_i = 0, ext_we_o;
  logic [1:0] ext_size_o;
  logic [31:0] ext_addr_o, ext_wdata_o, ext_rdata_i = 0;
  logic done_o, rd_we_o;
  logic [31:0] rd_data_o, hi_data_o;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  logic [31:0] hi_m = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lram_lsu dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", cycles, 150000);
      finish_run();
    end
  end

  task automatic set_hi(input logic [31:0] v);
    @(negedge clk_i); hi_wr_i = 1; hi_wdata_i = v;
    @(negedge clk_i); hi_wr_i = 0;
    chk(hi_data_o == v, "R12 hi write", hi_data_o, v);
    hi_m = v;
  endtask

  task automatic run_op(input bit st, input logic [1:0] sz, input logic [1:0] md,
                        input bit bs, input logic [31:0] rm, input logic [31:0] ba,
                        input logic [31:0] bb, input logic [4:0] imm,
                        input logic [31:0] rn, input bit junk, input string req);
    logic [31:0] base, ea, a0, a1, old, e_wd [2], e_ad [2], e_rd, e_hi;
    logic [31:0] t_ad [4], t_wd [4], p_ad, p_wd;
    bit t_loc [4], t_we [4], e_we [2], loc, done_seen, p_pend, p_loc;
    logic [1:0] t_sz [4], e_sz;
    int en, n, cyc;
    base = bs ? bb : ba;
    unique case (md)
      2'd1: ea = base + rm;
      2'd2: ea = base + ((imm == 0) ? 32'd128 : {25'd0, imm, 2'b00});
      default: ea = rm;
    endcase
    loc = (ea >= WLO) && (ea <= WHI) && (sz != 2'd0);
    a0 = ea;
    if (loc) begin
      if (sz == 2'd1) a0 = st ? (ea & ~32'd3) : (ea & ~32'd1);
      else if (sz == 2'd2) a0 = ea & ~32'd3;
      else a0 = ea & ~32'd7;
    end
    a1 = (sz == 2'd3) ? a0 + 32'd4 : a0;
    en = (sz == 2'd3 || (loc && st && sz == 2'd1)) ? 2 : 1;
    old = mem_f(a0);
    e_ad[0] = a0; e_ad[1] = a1;
    e_wd[0] = (sz == 2'd3) ? hi_m : rn;
    e_wd[1] = (sz == 2'd3) ? rn : (ea[1] ? {old[31:16], rn[15:0]} : {rn[15:0], old[15:0]});
    e_we[0] = st && !(en == 2 && sz == 2'd1);
    e_we[1] = st;
    e_sz = (sz == 2'd3) ? 2'd2 : sz;
    unique case (sz)
      2'd0: e_rd = {24'd0, old[7:0]};
      2'd1: e_rd = {16'd0, old[15:0]};
      2'd2: e_rd = old;
      default: e_rd = mem_f(a1);
    endcase
    e_hi = (!st && sz == 2'd3) ? old : hi_m;

    @(negedge clk_i);
    start_i = 1; store_i = st; size_i = sz; mode_i = md; base_sel_i = bs;
    rm_i = rm; base_a_i = ba; base_b_i = bb; imm_i = imm; rn_i = rn;
    n = 0; cyc = 0; done_seen = 0; p_pend = 0; p_loc = 0; p_ad = 0; p_wd = 0;
    while (!done_seen && cyc < 300) begin
      @(negedge clk_i); cyc++;
      if (cyc == 1 && junk) begin
        start_i = 1; rm_i = ~rm; rn_i = ~rn; size_i = ~sz;
      end else start_i = 0;
      if (done_o) begin
        done_seen = 1;
        chk(rd_we_o == !st, "R10 rd_we on done", {31'd0, rd_we_o}, {31'd0, !st});
        chk(hi_data_o == hi_m, "R10 hi unchanged at done", hi_data_o, hi_m);
        if (!st) chk(rd_data_o == e_rd, req, rd_data_o, e_rd);
      end else begin
        if (p_pend) begin
          if (p_loc) chk(lram_valid_o && lram_addr_o == p_ad && lram_wdata_o == p_wd,
                         "R9 lram hold", lram_addr_o, p_ad);
          else chk(ext_valid_o && ext_addr_o == p_ad && ext_wdata_o == p_wd,
                   "R9 ext hold", ext_addr_o, p_ad);
        end
        lram_ready_i = ($urandom % 3) != 0;
        ext_ready_i  = ($urandom % 3) != 0;
        lram_rdata_i = mem_f(lram_addr_o);
        ext_rdata_i  = mem_f(ext_addr_o);
        p_pend = 0;
        if (lram_valid_o || ext_valid_o) begin
          p_loc = lram_valid_o;
          p_ad = lram_valid_o ? lram_addr_o : ext_addr_o;
          p_wd = lram_valid_o ? lram_wdata_o : ext_wdata_o;
          if ((lram_valid_o && lram_ready_i) || (ext_valid_o && ext_ready_i)) begin
            if (n < 4) begin
              t_loc[n] = lram_valid_o; t_ad[n] = p_ad; t_wd[n] = p_wd;
              t_we[n] = lram_valid_o ? lram_we_o : ext_we_o; t_sz[n] = ext_size_o;
            end
            n++;
          end else p_pend = 1;
        end
      end
    end
    start_i = 0; lram_ready_i = 0; ext_ready_i = 0;
    chk(done_seen, "R10 done seen", {31'd0, done_seen}, 32'd1);
    chk(n == en, {req, " transfer count"}, n, en);
    for (int i = 0; i < en && i < n; i++) begin
      chk(t_loc[i] == loc, "R1 port choice", {31'd0, t_loc[i]}, {31'd0, loc});
      chk(t_ad[i] == e_ad[i], {req, " address"}, t_ad[i], e_ad[i]);
      chk(t_we[i] == e_we[i], {req, " write enable"}, {31'd0, t_we[i]}, {31'd0, e_we[i]});
      if (e_we[i]) chk(t_wd[i] == e_wd[i], {req, " write data"}, t_wd[i], e_wd[i]);
      if (!loc) chk(t_sz[i] == e_sz, "R8 ext size", {30'd0, t_sz[i]}, {30'd0, e_sz});
    end
    @(negedge clk_i);
    chk(hi_data_o == e_hi, (sz == 2'd3) ? "R4 hi after op" : "R10 hi after op", hi_data_o, e_hi);
    hi_m = e_hi;
    for (int k = 0; k < 2; k++) begin
      chk(!lram_valid_o && !ext_valid_o, "R11 idle after done",
          {30'd0, lram_valid_o, ext_valid_o}, 32'd0);
      @(negedge clk_i);
    end
  endtask

  function automatic logic [31:0] near_win();
    unique case ($urandom % 4)
      0: return WLO - 32'd64 + ($urandom % 128);
      1: return WHI - 32'd63 + ($urandom % 128);
      2: return WLO + ($urandom % 32'h1000);
      default: return $urandom % 32'h10000;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!done_o && !lram_valid_o && !ext_valid_o, "R10 reset idle",
        {29'd0, done_o, lram_valid_o, ext_valid_o}, 32'd0);
    chk(hi_data_o == 0, "R12 reset hi", hi_data_o, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);

    run_op(0, 2'd2, 2'd0, 0, 32'h00F0_3003, 0, 0, 0, 0, 0, "R3 local long align");
    run_op(1, 2'd2, 2'd0, 0, 32'h00F0_2FFF, 0, 0, 0, 32'hCAFE_0001, 0, "R3 ext long below window");
    run_op(0, 2'd2, 2'd0, 0, 32'h00F0_3FFF, 0, 0, 0, 0, 1, "R1 top of window");
    run_op(0, 2'd2, 2'd0, 0, 32'h00F0_4000, 0, 0, 0, 0, 0, "R1 above window");
    run_op(0, 2'd2, 2'd2, 0, 0, 32'h00F0_3000, 32'h5, 5'd0, 0, 0, "R2 imm zero is 32");
    run_op(0, 2'd2, 2'd2, 1, 0, 32'h7, 32'h00F0_3100, 5'd3, 0, 0, "R2 imm scaled second base");
    run_op(0, 2'd2, 2'd1, 0, 32'h25, 32'h00F0_3000, 0, 0, 0, 0, "R2 base plus reg");
    set_hi(32'h1111_2222);
    run_op(1, 2'd3, 2'd0, 0, 32'h00F0_3006, 0, 0, 0, 32'h3333_4444, 0, "R4 local phrase store");
    run_op(0, 2'd3, 2'd0, 0, 32'h00F0_300C, 0, 0, 0, 0, 1, "R4 local phrase load");
    run_op(0, 2'd3, 2'd0, 0, 32'h0000_1002, 0, 0, 0, 0, 0, "R5 ext phrase load");
    set_hi(32'hABCD_EF01);
    run_op(1, 2'd3, 2'd0, 0, 32'h0000_1003, 0, 0, 0, 32'h5555_6666, 0, "R5 ext phrase store");
    run_op(1, 2'd1, 2'd0, 0, 32'h00F0_3002, 0, 0, 0, 32'h0000_BEEF, 0, "R6 word store low half");
    run_op(1, 2'd1, 2'd0, 0, 32'h00F0_3001, 0, 0, 0, 32'h0000_F00D, 1, "R6 word store high half");
    run_op(0, 2'd1, 2'd0, 0, 32'h00F0_3003, 0, 0, 0, 0, 0, "R7 local word load");
    run_op(0, 2'd1, 2'd0, 0, 32'h0000_2001, 0, 0, 0, 0, 0, "R8 ext word load");
    run_op(0, 2'd0, 2'd0, 0, 32'h00F0_3005, 0, 0, 0, 0, 0, "R8 byte in window goes ext");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz, md;
      logic [31:0] t;
      sz = 2'($urandom % 4);
      md = 2'($urandom % 4);
      t = near_win();
      if (($urandom % 8) == 0) set_hi($urandom);
      run_op(1'($urandom % 2), sz, md, 1'($urandom % 2),
             (md == 2'd1) ? ($urandom % 64) : t, t, t + 32'd4, 5'($urandom % 32),
             $urandom, 1'($urandom % 2),
             (sz == 2'd3) ? "R4 random phrase" : (sz == 2'd1) ? "R6 random word" : "R8 random");
    end
    finish_run();
  end
endmodule